// File: doc/BRIEF.md
# Dual Carrier Generator with Duty-Cycle Downlink Modulation

This block is the digital front end of an external wireless power and data transmitter. A single fast reference clock (nominally 108.48 MHz) is divided down to two carriers: a main carrier at one eighth of the reference (13.56 MHz) that carries both power and a low-rate downlink, and a secondary carrier at one quarter of the reference (27.12 MHz) that is kept running for the high-rate uplink path. Each carrier leaves the block as a pair of complementary, non-overlapping gate drives intended for the two switches of a half-bridge stage. A one-reference-cycle dead time is removed from the high phase of every drive, so the two switches of a pair never conduct at the same time.

Downlink bytes arrive on a parallel bus with a valid/ready handshake. Each accepted byte is framed with a leading zero start bit and sent most significant bit first. Each bit is Manchester coded into two half-bits by XOR with a serial clock at twice the bit rate. Each half-bit sets the main carrier's duty cycle: a high level keeps it at 50 % and a low level cuts it to 25 %. Duty changes only take effect at carrier-period boundaries, so no runt pulses reach the power stage. Between frames the main carrier runs at 50 % so power transfer continues. When the transmit enable is low, all drives are held low and any frame in progress is dropped.

Top module: `dualCarrierGen`

## Requirements
- R1: With txEnable high, the main drive pair repeats every MAIN_DIV (default 8) reference cycles and the uplink pair every UP_DIV (default 4) cycles. A rising edge of mainHi is always a rising edge of upHi too.
- R2: Within each pair the two drives are never high together. A drive never goes high in the cycle right after its partner was high, so there is at least one idle cycle at each hand-over.
- R3: At level 1 (50 % duty), mainHi is high for MAIN_DIV/2-1 cycles (3) and mainLo for MAIN_DIV/2-1 cycles (3) per period.
- R4: At level 0 (25 % duty), mainHi is high for MAIN_DIV/4-1 cycles (1) and mainLo for 3*MAIN_DIV/4-1 cycles (5) per period.
- R5: A frame has 2*(DATA_W+1) half-bits, each HALF_BIT_PERIODS main periods long (default 64). It is a 0 start bit followed by txData MSB first. The level of a half-bit is the bit XOR the half index (first half = bit, second half = inverted bit).
- R6: The duty level changes only at main carrier period boundaries.
- R7: A byte is accepted on a cycle with txValid and txReady both high; txReady is low in the following cycle.
- R8: txReady rises after the last half-bit of a frame, and the main carrier returns to 50 % duty.
- R9: When txEnable is low, all four drives are low on the next cycle, txReady is low, and any pending or in-progress frame is discarded. After re-enable, mainHi and upHi start high at once and the main carrier runs at 50 %.
- R10: The uplink pair ignores downlink data: upHi and upLo are each high for one cycle per four-cycle period in every frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Enables both carriers and the downlink |
| txData | input | DATA_W | Byte to send |
| txValid | input | 1 | txData holds a byte to send |
| txReady | output | 1 | Block can accept a byte |
| mainHi | output | 1 | Main carrier high-side drive |
| mainLo | output | 1 | Main carrier low-side drive |
| upHi | output | 1 | Uplink carrier high-side drive |
| upLo | output | 1 | Uplink carrier low-side drive |

## Verification
On every cycle, the embedded assertions check drive non-overlap and the idle gap at each hand-over, all-low drives after a disable, that the duty level only moves at a period end, the alignment of the two carriers, the drop of txReady after a handshake and its return when a frame ends. Only the bench's scenarios can show that a frame carries the right bits in the right order with the right half-bit length, that the pulse widths match the two duty levels, and that a frame cut short by a disable leaves no trace once the carriers restart. The bench sweeps bytes with edge patterns (all zeros, all ones, alternating, single bits) and a spread of others, using a short half-bit length.

// File: rtl/dcgPkg.sv
package dcgPkg;
  // Command from the downlink control to the carrier datapath.
  typedef struct packed {
    logic run;       // carriers enabled
    logic fullDuty;  // 1: 50 % duty, 0: 25 % duty on the main carrier
  } carrierCmd_t;
endpackage

// File: rtl/carrierPair.sv
module carrierPair #(
  parameter int DIV = 8,
  parameter int DEAD = 1,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int LW = $clog2(DIV + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [LW-1:0] highLen,
  output logic          hi,
  output logic          lo,
  output logic          periodLast
);
  logic [PW-1:0] phase;
  logic          atEnd;

  assign atEnd      = (phase == PW'(DIV - 1));
  assign periodLast = run && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else if (!run) begin
      phase <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else begin
      phase <= atEnd ? '0 : phase + 1'b1;
      hi    <= (int'(phase) < int'(highLen) - DEAD);
      lo    <= (int'(phase) >= int'(highLen)) && (int'(phase) < DIV - DEAD);
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN) !(hi && lo));
  assert_gap_after_hi_R2: assert property (@(posedge clk) disable iff (!rstN) hi |=> !lo);
  assert_gap_after_lo_R2: assert property (@(posedge clk) disable iff (!rstN) lo |=> !hi);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rstN) !run |=> (!hi && !lo));
endmodule

// File: rtl/carrierPath.sv
module carrierPath
  import dcgPkg::*;
#(
  parameter int MAIN_DIV = 8,
  parameter int UP_DIV = 4,
  parameter int DEAD = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  carrierCmd_t cmd,
  output logic        mainHi,
  output logic        mainLo,
  output logic        upHi,
  output logic        upLo,
  output logic        mainPeriodLast
);
  localparam int NUM_CARRIERS = 2;
  localparam int MAIN_LW = $clog2(MAIN_DIV + 1);

  logic [MAIN_LW-1:0] mainHighLen;
  logic [NUM_CARRIERS-1:0] hiVec, loVec, lastVec;

  // Duty selection for the main carrier: half or quarter of the period.
  assign mainHighLen = cmd.fullDuty ? MAIN_LW'(MAIN_DIV / 2) : MAIN_LW'(MAIN_DIV / 4);

  for (genvar c = 0; c < NUM_CARRIERS; c++) begin : carrier
    localparam int D = (c == 0) ? MAIN_DIV : UP_DIV;
    localparam int LW = $clog2(D + 1);
    logic [LW-1:0] len;
    if (c == 0) begin : modulated
      assign len = mainHighLen;
    end else begin : steady
      assign len = LW'(D / 2);
    end
    carrierPair #(.DIV(D), .DEAD(DEAD)) pair (
      .clk        (clk),
      .rstN       (rstN),
      .run        (cmd.run),
      .highLen    (len),
      .hi         (hiVec[c]),
      .lo         (loVec[c]),
      .periodLast (lastVec[c])
    );
  end

  assign mainHi         = hiVec[0];
  assign mainLo         = loVec[0];
  assign upHi           = hiVec[1];
  assign upLo           = loVec[1];
  assign mainPeriodLast = lastVec[0];

  // Both counters restart together, so a main period end is an uplink period end.
  assert_carriers_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    lastVec[0] |-> lastVec[1]);
endmodule

// File: rtl/downlinkCtrl.sv
module downlinkCtrl
  import dcgPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_BIT_PERIODS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              periodLast,
  output logic              txReady,
  output carrierCmd_t       cmd
);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int PCW = (HALF_BIT_PERIODS > 1) ? $clog2(HALF_BIT_PERIODS) : 1;
  localparam int BCW = $clog2(FRAME_BITS + 1);

  logic              pending, busy, halfOdd;
  logic [DATA_W:0]   frameReg;
  logic [PCW-1:0]    periodCnt;
  logic [BCW-1:0]    bitCnt;
  logic              halfDone;

  assign txReady  = txEnable && !busy && !pending;
  assign halfDone = (periodCnt == PCW'(HALF_BIT_PERIODS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      busy      <= 1'b0;
      halfOdd   <= 1'b0;
      frameReg  <= '0;
      periodCnt <= '0;
      bitCnt    <= '0;
    end else if (!txEnable) begin
      pending   <= 1'b0;
      busy      <= 1'b0;
      halfOdd   <= 1'b0;
      periodCnt <= '0;
      bitCnt    <= '0;
    end else begin
      if (txValid && txReady) begin
        frameReg <= {1'b0, txData};  // start bit ahead of the data
        pending  <= 1'b1;
      end
      if (periodLast) begin
        if (busy) begin
          if (halfDone) begin
            periodCnt <= '0;
            halfOdd   <= ~halfOdd;
            if (halfOdd) begin
              frameReg <= {frameReg[DATA_W-1:0], 1'b0};
              bitCnt   <= bitCnt + 1'b1;
              if (bitCnt == BCW'(FRAME_BITS - 1)) busy <= 1'b0;
            end
          end else begin
            periodCnt <= periodCnt + 1'b1;
          end
        end else if (pending) begin
          busy      <= 1'b1;
          pending   <= 1'b0;
          periodCnt <= '0;
          halfOdd   <= 1'b0;
          bitCnt    <= '0;
        end
      end
    end
  end

  // Manchester level: bit in the first half, its inverse in the second.
  assign cmd.run      = txEnable;
  assign cmd.fullDuty = busy ? (frameReg[DATA_W] ^ halfOdd) : 1'b1;

  assert_duty_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !periodLast) |=> $stable(cmd.fullDuty));
  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
  assert_ready_after_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (txReady || !txEnable));
endmodule

// File: rtl/dualCarrierGen.sv
module dualCarrierGen
  import dcgPkg::*;
#(
  parameter int MAIN_DIV = 8,
  parameter int UP_DIV = 4,
  parameter int DEAD = 1,
  parameter int DATA_W = 8,
  parameter int HALF_BIT_PERIODS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              mainHi,
  output logic              mainLo,
  output logic              upHi,
  output logic              upLo
);
  carrierCmd_t cmd;
  logic        mainPeriodLast;

  downlinkCtrl #(.DATA_W(DATA_W), .HALF_BIT_PERIODS(HALF_BIT_PERIODS)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .txData     (txData),
    .txValid    (txValid),
    .periodLast (mainPeriodLast),
    .txReady    (txReady),
    .cmd        (cmd)
  );

  carrierPath #(.MAIN_DIV(MAIN_DIV), .UP_DIV(UP_DIV), .DEAD(DEAD)) path (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (cmd),
    .mainHi         (mainHi),
    .mainLo         (mainLo),
    .upHi           (upHi),
    .upLo           (upLo),
    .mainPeriodLast (mainPeriodLast)
  );
endmodule

// File: tb/dualCarrierGen_test.sv
module dualCarrierGen_test;
  localparam int HALF = 4;
  localparam int HALVES = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0;
  logic [7:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady, mainHi, mainLo, upHi, upLo;

  int checks = 0;
  int failures = 0;

  dualCarrierGen #(.HALF_BIT_PERIODS(HALF)) uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txData(txData), .txValid(txValid),
    .txReady(txReady), .mainHi(mainHi), .mainLo(mainLo), .upHi(upHi), .upLo(upLo)
  );

  always #5 clk = ~clk;

  // Monitor state
  int hiW[0:1023];
  int loW[0:1023];
  int nHi = 0, nLo = 0;
  int hiRun = 0, loRun = 0, upHiRun = 0, upLoRun = 0;
  bit armed = 0, recording = 0;
  bit prevHi = 0, prevLo = 0, prevUpHi = 0, prevUpLo = 0;
  int cyc = 0, lastRise = -1, lastUpRise = -1;
  int badPeriod = 0, badOverlap = 0, badUp = 0, badAlign = 0;

  always @(negedge clk) begin
    cyc++;
    if (mainHi && mainLo) badOverlap++;
    if (upHi && upLo) badOverlap++;
    if ((prevHi && mainLo) || (prevLo && mainHi)) badOverlap++;
    if ((prevUpHi && upLo) || (prevUpLo && upHi)) badOverlap++;
    if (!txEnable) begin
      lastRise = -1;
      lastUpRise = -1;
    end
    if (mainHi && !prevHi) begin
      if (lastRise >= 0 && cyc - lastRise != 8) badPeriod++;
      lastRise = cyc;
      if (!(upHi && !prevUpHi)) badAlign++;
      if (armed) begin
        armed = 0; recording = 1; nHi = 0; nLo = 0;
      end
    end
    if (upHi && !prevUpHi) begin
      if (lastUpRise >= 0 && cyc - lastUpRise != 4) badUp++;
      lastUpRise = cyc;
    end
    if (mainHi) hiRun++;
    else if (hiRun > 0) begin
      if (recording && nHi < 1024) begin hiW[nHi] = hiRun; nHi++; end
      hiRun = 0;
    end
    if (mainLo) loRun++;
    else if (loRun > 0) begin
      if (recording && nLo < 1024) begin loW[nLo] = loRun; nLo++; end
      loRun = 0;
    end
    if (upHi) upHiRun++;
    else if (upHiRun > 0) begin if (upHiRun != 1) badUp++; upHiRun = 0; end
    if (upLo) upLoRun++;
    else if (upLoRun > 0) begin if (upLoRun != 1) badUp++; upLoRun = 0; end
    prevHi = mainHi; prevLo = mainLo; prevUpHi = upHi; prevUpLo = upLo;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Expected main pulse width for half-bit h of a frame carrying b.
  function automatic int expWidth(input logic [7:0] b, input int h);
    int bi = h / 2;
    logic bitv = (bi == 0) ? 1'b0 : b[8 - bi];
    logic lvl = bitv ^ logic'(h % 2);
    return lvl ? 3 : 1;
  endfunction

  task automatic sendAndCheck(input logic [7:0] b);
    int t, first, bad, badLo, idleBad;
    t = 0;
    while (!txReady && t < 2000) begin @(negedge clk); t++; end
    txData = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(txReady == 1'b0, "R7 ready low after accept", int'(txReady), 0);
    armed = 1; recording = 0;
    t = 0;
    while (!txReady && t < 5000) begin @(negedge clk); t++; end
    check(t < 5000, "R8 ready returns after frame", t, 0);
    waitCycles(8 * 4);
    recording = 0;
    first = -1;
    for (int i = 0; i < nHi; i++) if (first < 0 && hiW[i] == 1) first = i;
    check(first >= 0 && first <= 2, "R5 start bit begins frame", first, 1);
    if (first < 0) first = 0;
    bad = 0; badLo = 0;
    for (int h = 0; h < HALVES; h++)
      for (int p = 0; p < HALF; p++) begin
        int idx = first + h * HALF + p;
        if (idx >= nHi || hiW[idx] != expWidth(b, h)) bad++;
        if (idx >= nLo || loW[idx] != (expWidth(b, h) == 3 ? 3 : 5)) badLo++;
      end
    check(bad == 0, $sformatf("R5 frame pulses for byte %02h", b), bad, 0);
    check(badLo == 0, "R3 R4 low-side widths match duty", badLo, 0);
    idleBad = 0;
    for (int i = 0; i < first; i++) if (hiW[i] != 3) idleBad++;
    for (int i = first + HALVES * HALF; i < nHi; i++) if (hiW[i] != 3) idleBad++;
    check(idleBad == 0 && nHi >= first + HALVES * HALF + 2, "R8 back to 50% duty", idleBad, 0);
  endtask

  initial begin
    waitCycles(200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int idle;
    logic [7:0] patterns [6];
    patterns[0] = 8'h00; patterns[1] = 8'hFF; patterns[2] = 8'hA5;
    patterns[3] = 8'h5A; patterns[4] = 8'h01; patterns[5] = 8'h80;
    waitCycles(3);
    check({mainHi, mainLo, upHi, upLo} == 4'b0, "R9 outputs low in reset",
          int'({mainHi, mainLo, upHi, upLo}), 0);
    rstN = 1'b1;
    waitCycles(3);
    check(txReady == 1'b0, "R9 ready low while disabled", int'(txReady), 0);
    check({mainHi, mainLo, upHi, upLo} == 4'b0, "R9 drives low while disabled",
          int'({mainHi, mainLo, upHi, upLo}), 0);

    txEnable = 1'b1;
    @(negedge clk);
    check(mainHi && upHi, "R9 high sides start at enable", int'({mainHi, upHi}), 3);
    check(txReady == 1'b1, "R7 ready when idle", int'(txReady), 1);
    armed = 1;
    waitCycles(8 * 10);
    recording = 0;
    idle = 0;
    for (int i = 0; i < nHi; i++) if (hiW[i] != 3 || loW[i] != 3) idle++;
    check(idle == 0 && nHi >= 8, "R3 idle 50% duty widths", idle, 0);

    foreach (patterns[k]) sendAndCheck(patterns[k]);
    for (int k = 0; k < 14; k++) sendAndCheck(8'(k * 37 + 11));

    // Disable in the middle of a frame.
    txData = 8'h00; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    waitCycles(8 * 6 + 3);
    txEnable = 1'b0;
    check(txReady == 1'b0, "R9 ready low on disable", int'(txReady), 0);
    idle = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mainHi || mainLo || upHi || upLo) idle++;
    end
    check(idle == 0, "R9 drives held low", idle, 0);
    txEnable = 1'b1;
    @(negedge clk);
    check(mainHi && upHi, "R9 restart with high sides", int'({mainHi, upHi}), 3);
    armed = 1;
    waitCycles(8 * 30);
    recording = 0;
    idle = 0;
    for (int i = 0; i < nHi; i++) if (hiW[i] != 3) idle++;
    check(idle == 0 && nHi >= 25, "R9 dropped frame leaves 50% carrier", idle, 0);
    check(txReady == 1'b1, "R9 ready after restart", int'(txReady), 1);

    check(badPeriod == 0, "R1 main period 8 cycles", badPeriod, 0);
    check(badAlign == 0, "R1 carriers rise together", badAlign, 0);
    check(badOverlap == 0, "R2 no overlap and hand-over gap", badOverlap, 0);
    check(badUp == 0, "R10 uplink pair unchanged by data", badUp, 0);
    check(badPeriod == 0 && badOverlap == 0, "R6 no runt pulses at duty change", badPeriod, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule